// File: doc/BRIEF.md
# Power-to-Pulse Dual-Phase Converter

This block turns a stream of signed, already filtered real-power samples into two alternating active-low pulse trains. The trains are suitable for driving a two-phase stepper motor or an impulse counter. One sample arrives with each clock-enable tick, and the ticks come from a nominal 450 kHz time base. The magnitude of each sample is added to an accumulator. Whenever the accumulator reaches a threshold, the threshold is taken off, the remainder is kept, and one output pulse is requested. The requests take turns between the two outputs, so the second output falls half an output period after the first.

A 2-bit select chooses one of four full-scale rates by dividing a base threshold by a power of two. The pulse width is fixed at a nominal value. When pulses come faster than that width plus a guard time allows, the width shrinks to fit the measured spacing, which keeps a minimum high gap between the two outputs. A no-load level blocks creep: a sample whose magnitude is below that level issues no request and empties the accumulator. One request that arrives while a pulse is still running is held and served once the guard time ends.

Top module: `power_pulse_pair`

## Requirements
- R1: A synchronous active-high reset drives both outputs high (inactive) and clears the accumulator. After reset, the first pulse appears on `f1_n`.
- R2: On each tick, the magnitude of the sample is added to the accumulator. When the sum reaches the threshold `BASE_THR >> fs_sel` (select value k divides the base threshold by 2^k, so 0 is the slowest rate), one pulse is requested and the remainder is kept. Starting from reset, N ticks of a constant magnitude m above the no-load level therefore give floor(N*m/threshold) pulses.
- R3: A negative sample adds the same amount as a positive sample of equal magnitude.
- R4: Pulses alternate strictly: the 1st, 3rd, 5th and later pulses go to `f1_n`, and the 2nd, 4th and later pulses go to `f2_n`. The two outputs are never low together. At a steady rate, `f2_n` falls one request interval, which is half the `f1_n` period, after `f1_n`.
- R5: A tick whose sample magnitude is below `NOLOAD_MIN` issues no request. A magnitude equal to `NOLOAD_MIN` is accumulated normally.
- R6: A tick whose sample is below the no-load level sets the accumulator to zero, so no partial energy survives the no-load interval.
- R7: A pulse lasts `W_TICKS` ticks when the interval between the last two requests is at least `W_TICKS + GAP_TICKS` ticks. The same holds when only one request has been seen since reset.
- R8: When the last request interval T is shorter than that, the pulse lasts T - `GAP_TICKS` ticks, with a minimum of 1.
- R9: At least `GAP_TICKS` ticks of both outputs high separate the end of one pulse from the start of the next.
- R10: A request that arrives while a pulse or its guard time is running is held, up to one request. It starts on the tick that ends the guard time.
- R11: A clock cycle with `tick` low changes neither the outputs nor the accumulator, whatever the sample input carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Clock enable and sample strobe from the 450 kHz time base |
| power_smp | input | SAMPLE_W | Signed filtered real-power sample, valid when `tick` is high |
| fs_sel | input | SEL_W | Full-scale rate select; value k divides the threshold by 2^k |
| f1_n | output | 1 | First-phase pulse output, active low |
| f2_n | output | 1 | Second-phase pulse output, active low |

## Verification
The bench sweeps every select value against several sample magnitudes and checks the pulse count on each output against floor(N*m/threshold). A design that loses the remainder, uses the wrong threshold scaling or mishandles negative samples would give different counts. Magnitudes just at and just below the no-load level show whether the no-load comparison is off by one. A no-load sample placed between two partial accumulations would let a design that keeps the residue fire a stray pulse.

At the highest rate, the bench measures the pulse width and the high gap. It also sets up a request that arrives during a long first pulse and times when it is served. A design that never shrinks the width, drops the held request or starts it before the guard time ends would show a wrong width, a missing pulse or a short gap. Cycles with the tick low, with a full-scale sample on the input, show whether the design ever accumulates without the enable.

// File: rtl/pp_pkg.sv
package pp_pkg;
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_LOW   = 2'd1,
      PH_GUARD = 2'd2
   } pulse_st_t;
endpackage

// File: rtl/pp_accum.sv
module pp_accum #(
   parameter int              SAMPLE_W   = 16,
   parameter int              ACC_W      = 40,
   parameter int              SEL_W      = 2,
   parameter longint unsigned BASE_THR   = 64'd42125000000,
   parameter int              NOLOAD_MIN = 1
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       tick,
   input  logic signed [SAMPLE_W-1:0] smp,
   input  logic [SEL_W-1:0]           sel,
   output logic                       req
);
   logic [ACC_W-1:0]    acc;
   logic [ACC_W-1:0]    thr;
   logic [ACC_W-1:0]    sum;
   logic [SAMPLE_W-1:0] mag;
   logic                creep;

   // magnitude: two's complement negate of negative samples, most negative value included
   always_comb begin
      mag   = smp[SAMPLE_W-1] ? (~smp + 1'b1) : smp;
      creep = (mag < SAMPLE_W'(NOLOAD_MIN));
      thr   = ACC_W'(BASE_THR) >> sel;
      sum   = acc + ACC_W'(mag);
      req   = tick && !creep && (sum >= thr);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         acc <= '0;
      end else if (tick) begin
         if (creep)           acc <= '0;
         else if (sum >= thr) acc <= sum - thr;
         else                 acc <= sum;
      end
   end

   // R2
   accum_bound_chk: assert property (@(posedge clk) disable iff (rst)
      $stable(sel) |-> (acc < thr));
   // R6
   creep_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (tick && (mag < SAMPLE_W'(NOLOAD_MIN))) |=> (acc == '0));
   // R11
   acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !tick |=> $stable(acc));
endmodule

// File: rtl/pp_interval.sv
module pp_interval #(
   parameter int W_TICKS   = 54000,
   parameter int GAP_TICKS = 1,
   parameter int CW        = 16
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          tick,
   input  logic          req,
   output logic [CW-1:0] width
);
   localparam logic [CW-1:0] CAP = CW'(W_TICKS + GAP_TICKS);
   localparam logic [CW-1:0] GAP = CW'(GAP_TICKS);

   logic [CW-1:0] ivl;
   logic [CW-1:0] t_last;

   // ivl starts saturated so the first request counts as a long interval
   always_ff @(posedge clk) begin
      if (rst) begin
         ivl    <= CAP;
         t_last <= CAP;
      end else if (tick) begin
         if (req) begin
            t_last <= (ivl >= CAP) ? CAP : ivl + 1'b1;
            ivl    <= '0;
         end else if (ivl < CAP) begin
            ivl <= ivl + 1'b1;
         end
      end
   end

   always_comb begin
      if (t_last >= CAP)     width = CW'(W_TICKS);
      else if (t_last > GAP) width = t_last - GAP;
      else                   width = CW'(1);
   end

   // R8
   width_fit_chk: assert property (@(posedge clk) disable iff (rst)
      (width >= CW'(1)) && (width <= CW'(W_TICKS)));
endmodule

// File: rtl/pp_pulse.sv
module pp_pulse
   import pp_pkg::*;
#(
   parameter int W_TICKS   = 54000,
   parameter int GAP_TICKS = 1,
   parameter int CW        = 16
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          tick,
   input  logic          req,
   input  logic [CW-1:0] width,
   output logic          f1_n,
   output logic          f2_n
);
   pulse_st_t     st;
   logic [CW-1:0] cnt;
   logic          pend;
   logic          nxt_ch;
   logic          cur_ch;
   logic          go;

   always_comb begin
      go   = pend && ((st == PH_IDLE) || ((st == PH_GUARD) && (cnt == '0)));
      f1_n = !((st == PH_LOW) && !cur_ch);
      f2_n = !((st == PH_LOW) &&  cur_ch);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st     <= PH_IDLE;
         cnt    <= '0;
         pend   <= 1'b0;
         nxt_ch <= 1'b0;
         cur_ch <= 1'b0;
      end else if (tick) begin
         if (go)       pend <= req;
         else if (req) pend <= 1'b1;
         if (go) begin
            st     <= PH_LOW;
            cnt    <= width - 1'b1;
            cur_ch <= nxt_ch;
            nxt_ch <= ~nxt_ch;
         end else begin
            unique case (st)
               PH_LOW: begin
                  if (cnt == '0) begin
                     st  <= PH_GUARD;
                     cnt <= CW'(GAP_TICKS - 1);
                  end else begin
                     cnt <= cnt - 1'b1;
                  end
               end
               PH_GUARD: begin
                  if (cnt == '0) st  <= PH_IDLE;
                  else           cnt <= cnt - 1'b1;
               end
               default: st <= PH_IDLE;
            endcase
         end
      end
   end

   // R11
   hold_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
      !tick |=> ($stable(f1_n) && $stable(f2_n) && $stable(cnt)));
   // R7
   width_cap_chk: assert property (@(posedge clk) disable iff (rst)
      (st == PH_LOW) |-> (cnt < CW'(W_TICKS)));
   // R9
   guard_gap_chk: assert property (@(posedge clk) disable iff (rst)
      (tick && (st == PH_LOW) && (cnt == '0)) |=> (f1_n && f2_n));
   // R10
   pend_served_chk: assert property (@(posedge clk) disable iff (rst)
      (tick && pend && (st == PH_IDLE)) |=> (st == PH_LOW));
   // R4
   never_both_low_chk: assert property (@(posedge clk) disable iff (rst)
      (f1_n || f2_n));
endmodule

// File: rtl/power_pulse_pair.sv
module power_pulse_pair #(
   parameter int              SAMPLE_W   = 16,
   parameter int              ACC_W      = 40,
   parameter int              SEL_W      = 2,
   parameter longint unsigned BASE_THR   = 64'd42125000000,
   parameter int              NOLOAD_MIN = 1,
   parameter int              W_TICKS    = 54000,
   parameter int              GAP_TICKS  = 1
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       tick,
   input  logic signed [SAMPLE_W-1:0] power_smp,
   input  logic [SEL_W-1:0]           fs_sel,
   output logic                       f1_n,
   output logic                       f2_n
);
   localparam int CW     = $clog2(W_TICKS + GAP_TICKS + 1);
   localparam int MAX_SH = (1 << SEL_W) - 1;

   if ((BASE_THR >> MAX_SH) < (64'd1 << SAMPLE_W)) begin : g_bad_thr
      $error("threshold at the fastest select must be at least 2**SAMPLE_W");
   end
   if (BASE_THR >= (64'd1 << (ACC_W - 1))) begin : g_bad_accw
      $error("ACC_W too narrow for BASE_THR");
   end
   if (GAP_TICKS < 1 || W_TICKS < 1) begin : g_bad_timing
      $error("W_TICKS and GAP_TICKS must be at least 1");
   end
   if (NOLOAD_MIN > (1 << (SAMPLE_W - 1))) begin : g_bad_noload
      $error("NOLOAD_MIN beyond sample range");
   end

   logic          req;
   logic [CW-1:0] width;

   pp_accum #(
      .SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W), .SEL_W(SEL_W),
      .BASE_THR(BASE_THR), .NOLOAD_MIN(NOLOAD_MIN)
   ) u_accum (
      .clk(clk), .rst(rst), .tick(tick), .smp(power_smp), .sel(fs_sel), .req(req)
   );

   pp_interval #(.W_TICKS(W_TICKS), .GAP_TICKS(GAP_TICKS), .CW(CW)) u_ivl (
      .clk(clk), .rst(rst), .tick(tick), .req(req), .width(width)
   );

   pp_pulse #(.W_TICKS(W_TICKS), .GAP_TICKS(GAP_TICKS), .CW(CW)) u_pulse (
      .clk(clk), .rst(rst), .tick(tick), .req(req), .width(width),
      .f1_n(f1_n), .f2_n(f2_n)
   );
endmodule

// File: tb/sim_power_pulse_pair.sv
module sim_power_pulse_pair;
   localparam int THR0 = 2048;
   localparam int WT   = 12;
   localparam int GT   = 2;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              tick = 1'b0;
   logic signed [7:0] smp = '0;
   logic [1:0]        sel = '0;
   logic              f1_n, f2_n;

   int total = 0, failed = 0;
   bit done = 1'b0;

   power_pulse_pair #(
      .SAMPLE_W(8), .ACC_W(16), .SEL_W(2), .BASE_THR(64'd2048),
      .NOLOAD_MIN(4), .W_TICKS(WT), .GAP_TICKS(GT)
   ) u0 (
      .clk(clk), .rst(rst), .tick(tick), .power_smp(smp), .fs_sel(sel),
      .f1_n(f1_n), .f2_n(f2_n)
   );

   always #2 clk = ~clk;

   // output monitor, sampled on the falling clock edge
   int  cyc = 0;
   int  falls1, falls2, fall1_at, fall2_at, last_w1, last_w2, last_w, last_rise, min_gap, both_low;
   bit  have_rise;
   logic p1 = 1'b1, p2 = 1'b1;

   always @(negedge clk) begin
      cyc++;
      if (p1 && !f1_n) begin
         falls1++; fall1_at = cyc;
         if (have_rise && (cyc - last_rise) < min_gap) min_gap = cyc - last_rise;
      end
      if (p2 && !f2_n) begin
         falls2++; fall2_at = cyc;
         if (have_rise && (cyc - last_rise) < min_gap) min_gap = cyc - last_rise;
      end
      if (!p1 && f1_n) begin last_w1 = cyc - fall1_at; last_w = last_w1; last_rise = cyc; have_rise = 1'b1; end
      if (!p2 && f2_n) begin last_w2 = cyc - fall2_at; last_w = last_w2; last_rise = cyc; have_rise = 1'b1; end
      if (!f1_n && !f2_n) both_low++;
      p1 = f1_n; p2 = f2_n;
   end

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         failed++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic clear_mon();
      falls1 = 0; falls2 = 0; fall1_at = 0; fall2_at = 0; last_w1 = 0; last_w2 = 0;
      last_w = 0; last_rise = 0; min_gap = 1000000; both_low = 0; have_rise = 1'b0;
   endtask

   task automatic do_reset(input int s);
      @(negedge clk); rst = 1'b1; tick = 1'b0; smp = '0; sel = 2'(s);
      repeat (3) @(negedge clk);
      rst = 1'b0;
      clear_mon();
   endtask

   task automatic feed(input int val, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick = 1'b1; smp = 8'(val);
         @(negedge clk); tick = 1'b0;
      end
   endtask

   task automatic count_run(input int s, input int val, input string tag);
      int m, exp;
      m = (val < 0) ? -val : val;
      do_reset(s);
      feed(val, 1600);
      feed(0, 40);
      exp = (m < 4) ? 0 : (1600 * m) / (THR0 >> s);
      chk({tag, " f1 count"}, falls1, (exp + 1) / 2);
      chk({"R4 f2 count"}, falls2, exp / 2);
   endtask

   initial begin
      #800000;
      if (!done) begin
         total++; failed++;
         $display("FAIL watchdog: got 1 expected 0");
         $display("%0d/%0d checks passed", total - failed, total);
         $finish;
      end
   end

   initial begin
      clear_mon();
      do_reset(0);
      repeat (2) @(negedge clk);
      // R1 reset state
      chk("R1 f1_n after reset", int'(f1_n), 1);
      chk("R1 f2_n after reset", int'(f2_n), 1);

      // R2 sweep over selects and magnitudes, R3 negative samples, R5 boundary
      for (int s = 0; s < 4; s++) begin
         count_run(s, 4, "R2 m=4");
         count_run(s, 9, "R2 m=9");
         count_run(s, 18, "R2 m=18");
         if (s < 2) begin
            count_run(s, 40, "R2 m=40");
            count_run(s, 64, "R2 m=64");
         end
         if (s == 0 || s == 2) count_run(s, -18, "R3 m=-18");
      end
      count_run(0, -64, "R3 m=-64");
      count_run(3, 3, "R5 below no-load");
      count_run(3, -3, "R5 below no-load negative");

      // R6 no-load sample empties the accumulator
      do_reset(0);
      feed(50, 40); feed(2, 1); feed(50, 40); feed(0, 40);
      chk("R6 residue cleared", falls1 + falls2, 0);

      // R4 half-period offset, R7 nominal width
      do_reset(0);
      feed(16, 300); feed(0, 40);
      chk("R4 pulse total", falls1 + falls2, 2);
      chk("R4 f2 after f1 cycles", fall2_at - fall1_at, 256);
      chk("R7 nominal width cycles", last_w1, 2 * WT);
      chk("R4 both low", both_low, 0);

      // R8 reduced width at fastest rate, R9 gap
      do_reset(3);
      feed(64, 200); feed(0, 40);
      chk("R8 width at T=4", last_w, 2 * (4 - GT));
      chk("R9 min gap cycles", min_gap, 2 * GT);
      chk("R4 both low fast", both_low, 0);
      do_reset(3);
      feed(32, 200); feed(0, 40);
      chk("R8 width at T=8", last_w, 2 * (8 - GT));
      chk("R9 gap at T=8", (min_gap >= 2 * GT) ? 1 : 0, 1);

      // R10 held request served at guard end
      do_reset(3);
      feed(64, 8); feed(0, 40);
      chk("R10 f1 count", falls1, 1);
      chk("R10 f2 count", falls2, 1);
      chk("R10 start delay cycles", fall2_at - fall1_at, 2 * (WT + GT));
      chk("R8 held pulse width", last_w2, 2 * (4 - GT));

      // R11 tick low ignores samples
      do_reset(3);
      feed(64, 3);
      @(negedge clk); smp = 8'sd127; tick = 1'b0;
      repeat (50) @(negedge clk);
      chk("R11 no pulse without tick", falls1 + falls2, 0);
      feed(64, 1); feed(0, 4);
      chk("R11 accumulator kept", falls1, 1);

      done = 1'b1;
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
   end
endmodule